// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block is a memory-mapped machine-level timer for a small 32-bit processor system. It keeps a free-running counter that spans two data words, and a compare value of the same span. Each half of both values is reached as a word through a simple register bus with an address, a write strobe, write data and combinational read data. The block raises a level timer-interrupt request that the core routes to its machine timer-pending bit, bit 7 of its pending register.

The counter advances once per `tick` pulse, with the carry from the low word into the high word taken in that same tick. On every tick the request is recomputed from the incremented count and the compare value. The test is deliberately asymmetric: a high count word above the high compare word fires, and so does an exact match of both halves. A count whose high word equals the compare high word while its low word has moved past the compare low word does not fire. While the whole compare value is zero, the request is held low.

Top module: `mtimer_cmp`

## Requirements
- R1: A synchronous active-high `rst` clears both counter words, both compare words and `timer_irq` to zero.
- R2: Each cycle with `tick` high adds one to the counter. Cycles with `tick` low leave the counter unchanged.
- R3: When the low counter word steps from all ones to zero, the high counter word increments in the same tick.
- R4: After a tick whose incremented high count word is greater than the high compare word, `timer_irq` is 1, provided the compare value is not zero.
- R5: After a tick whose incremented count equals the compare value in both words, `timer_irq` is 1. If the high words are equal and the low words differ, `timer_irq` is 0.
- R6: After a tick taken while both compare words are zero, `timer_irq` is 0.
- R7: `timer_irq` is a registered level that changes only on ticks. A compare write made between ticks has no effect on `timer_irq` until the next tick.
- R8: With `bus_we` low, `bus_rdata` shows the compare low word at offset 0x4000, the compare high word at 0x4004, the counter low word at 0xBFF8 and the counter high word at 0xBFFC. Every other offset, including 0x0000, reads as zero.
- R9: A write with `bus_we` high updates only the compare word at 0x4000 or 0x4004. Writes to 0xBFF8, 0xBFFC, 0x0000 or any other offset change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer advance pulse, one count per high cycle |
| bus_addr | input | ADDR_W (16) | Word offset from the block base |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| timer_irq | output | 1 | Level timer-interrupt request to the core |

## Verification
A lost carry shows at 0xBFFC one tick after the low word wraps. The error then persists, because the counter cannot be rewritten. A compare half that takes a stray write, or a decode that aliases the counter offsets, shows on the very next read of that offset. A wrong comparison shows on `timer_irq` one tick after the count reaches the compare value or moves past it. The equal-high, greater-low tick that must drop the request is the case that separates an ordinary greater-or-equal test from the required one. A zero compare value checked across a full low-word wrap exposes a missing zero gate.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

  localparam logic [15:0] OFS_SOFT   = 16'h0000;
  localparam logic [15:0] OFS_CMP_LO = 16'h4000;
  localparam logic [15:0] OFS_CMP_HI = 16'h4004;
  localparam logic [15:0] OFS_CNT_LO = 16'hBFF8;
  localparam logic [15:0] OFS_CNT_HI = 16'hBFFC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SOFT,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_CNT_LO,
    SEL_CNT_HI
  } mtmr_sel_e;

endpackage

// File: rtl/mtmr_decode.sv
module mtmr_decode
  import mtmr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output mtmr_sel_e         sel
);
  // Full-width match so offsets outside the low 16 bits never alias.
  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_SOFT))   sel = SEL_SOFT;
    if (addr == ADDR_W'(OFS_CMP_LO)) sel = SEL_CMP_LO;
    if (addr == ADDR_W'(OFS_CMP_HI)) sel = SEL_CMP_HI;
    if (addr == ADDR_W'(OFS_CNT_LO)) sel = SEL_CNT_LO;
    if (addr == ADDR_W'(OFS_CNT_HI)) sel = SEL_CNT_HI;
  end
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic [W-1:0] nxt_lo,
  output logic [W-1:0] nxt_hi,
  output logic         lo_wrap
);
  localparam int NWORDS = 2;

  logic [W-1:0] word_q   [NWORDS];
  logic [W-1:0] word_nxt [NWORDS];
  logic [NWORDS:0] carry;

  assign carry[0] = tick;

  // One adder stage per word; each stage's carry out feeds the next word.
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    assign carry[i+1]  = carry[i] & (&word_q[i]);
    assign word_nxt[i] = word_q[i] + W'(carry[i]);

    always_ff @(posedge clk) begin
      if (rst) word_q[i] <= '0;
      else     word_q[i] <= word_nxt[i];
    end
  end

  assign cnt_lo  = word_q[0];
  assign cnt_hi  = word_q[1];
  assign nxt_lo  = word_nxt[0];
  assign nxt_hi  = word_nxt[1];
  assign lo_wrap = carry[1];

  logic unused_top_carry;
  assign unused_top_carry = carry[NWORDS];
endmodule

// File: rtl/mtmr_compare.sv
module mtmr_compare #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] nxt_lo,
  input  logic [W-1:0] nxt_hi,
  output logic [W-1:0] cmp_lo,
  output logic [W-1:0] cmp_hi,
  output logic         fire_now,
  output logic         irq
);
  // Asymmetric match: high word strictly above, or an exact full match.
  function automatic logic fire_f(input logic [W-1:0] c_hi, input logic [W-1:0] c_lo,
                                  input logic [W-1:0] m_hi, input logic [W-1:0] m_lo);
    logic armed;
    armed = (m_hi != '0) || (m_lo != '0);
    return armed && ((c_hi > m_hi) || ((c_hi == m_hi) && (c_lo == m_lo)));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_lo <= '0;
      cmp_hi <= '0;
    end else begin
      if (wr_lo) cmp_lo <= wdata;
      if (wr_hi) cmp_hi <= wdata;
    end
  end

  assign fire_now = fire_f(nxt_hi, nxt_lo, cmp_hi, cmp_lo);

  always_ff @(posedge clk) begin
    if (rst)       irq <= 1'b0;
    else if (tick) irq <= fire_now;
  end
endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp
  import mtmr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              timer_irq
);
  mtmr_sel_e   sel;
  logic [DATA_W-1:0] cnt_lo, cnt_hi, nxt_lo, nxt_hi, cmp_lo, cmp_hi;
  logic        lo_wrap, fire_now, wr_cmp_lo, wr_cmp_hi;

  mtmr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  assign wr_cmp_lo = bus_we && (sel == SEL_CMP_LO);
  assign wr_cmp_hi = bus_we && (sel == SEL_CMP_HI);

  mtmr_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .nxt_lo(nxt_lo), .nxt_hi(nxt_hi),
    .lo_wrap(lo_wrap)
  );

  mtmr_compare #(.W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi), .wdata(bus_wdata),
    .nxt_lo(nxt_lo), .nxt_hi(nxt_hi),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .fire_now(fire_now), .irq(timer_irq)
  );

  always_comb begin
    unique case (sel)
      SEL_CMP_LO: bus_rdata = cmp_lo;
      SEL_CMP_HI: bus_rdata = cmp_hi;
      SEL_CNT_LO: bus_rdata = cnt_lo;
      SEL_CNT_HI: bus_rdata = cnt_hi;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk
  import mtmr_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         bus_we,
  input mtmr_sel_e    sel,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic [W-1:0] cmp_lo,
  input logic [W-1:0] cmp_hi,
  input logic         lo_wrap,
  input logic         fire_now,
  input logic         timer_irq
);
  logic wr_cmp;
  logic cmp_zero;
  logic want_irq;
  assign wr_cmp   = bus_we && (sel == SEL_CMP_LO || sel == SEL_CMP_HI);
  assign cmp_zero = (cmp_lo == '0) && (cmp_hi == '0);
  assign want_irq = !cmp_zero && ((cnt_hi > cmp_hi) || ({cnt_hi, cnt_lo} == {cmp_hi, cmp_lo}));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cnt_lo == '0 && cnt_hi == '0 && cmp_lo == '0 && cmp_hi == '0 && !timer_irq));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> {cnt_hi, cnt_lo} == (2*W)'($past({cnt_hi, cnt_lo}) + (2*W)'(1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({cnt_hi, cnt_lo}));

  p_carry_r3: assert property (@(posedge clk) disable iff (rst)
    lo_wrap |=> (cnt_lo == '0 && cnt_hi == W'($past(cnt_hi) + W'(1))));

  p_match_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_cmp) |=> (timer_irq == want_irq));

  p_zero_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && cmp_zero) |=> !timer_irq);

  p_level_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(timer_irq));

  p_irq_follows_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (timer_irq == $past(fire_now)));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE || sel == SEL_SOFT) |-> bus_rdata == '0);

  p_cmp_write_only_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_cmp |=> $stable({cmp_hi, cmp_lo}));
endmodule

bind mtimer_cmp mtmr_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we), .sel(sel),
  .bus_rdata(bus_rdata), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .lo_wrap(lo_wrap),
  .fire_now(fire_now), .timer_irq(timer_irq)
);

// File: tb/tb_mtimer_cmp.sv
module tb_mtimer_cmp;
  localparam int AW = 16;
  localparam int W  = 8;   // narrow words make a low-word wrap reachable

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          timer_irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [2*W-1:0] m_cnt = '0;
  logic [W-1:0]   m_cmp_lo = '0, m_cmp_hi = '0;
  logic           m_irq = 1'b0;

  always #5 clk = ~clk;

  mtimer_cmp #(.ADDR_W(AW), .DATA_W(W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq(timer_irq)
  );

  // {offset, write, wdata, expected read-back of the same offset}
  typedef struct packed {
    logic [15:0] ofs;
    logic        we;
    logic [7:0]  wd;
    logic [7:0]  exp;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'h4000, 1'b1, 8'h5A, 8'h5A},  // R9 compare low writable
    '{16'h4004, 1'b1, 8'h03, 8'h03},  // R9 compare high writable
    '{16'hBFF8, 1'b1, 8'h77, 8'h00},  // R9 counter low ignores writes
    '{16'hBFFC, 1'b1, 8'h66, 8'h00},  // R9 counter high ignores writes
    '{16'h0000, 1'b1, 8'h11, 8'h00},  // R8 offset zero reads zero
    '{16'h0008, 1'b0, 8'h00, 8'h00},  // R8 unmapped
    '{16'h4008, 1'b0, 8'h00, 8'h00},  // R8 unmapped next to compare
    '{16'h4000, 1'b0, 8'h00, 8'h5A}   // R8 compare low retained
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [15:0] ofs, input logic [W-1:0] exp);
    @(negedge clk);
    bus_addr = ofs;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic bus_write(input logic [15:0] ofs, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = ofs; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (ofs == 16'h4000) m_cmp_lo = d;
    if (ofs == 16'h4004) m_cmp_hi = d;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_cnt = '0; m_cmp_lo = '0; m_cmp_hi = '0; m_irq = 1'b0;
  endtask

  // One tick, then compare count and request against the model.
  task automatic do_tick();
    string tag;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    m_cnt = m_cnt + 1'b1;
    if ({m_cmp_hi, m_cmp_lo} == '0) begin
      m_irq = 1'b0; tag = "R6";
    end else if (m_cnt[2*W-1:W] > m_cmp_hi) begin
      m_irq = 1'b1; tag = "R4";
    end else begin
      m_irq = (m_cnt == {m_cmp_hi, m_cmp_lo}); tag = "R5";
    end
    n_checks++;
    if (timer_irq !== m_irq) begin
      n_fails++;
      $display("FAIL %s: irq actual %0b expected %0b at count %0h", tag, timer_irq, m_irq, m_cnt);
    end
    bus_addr = 16'hBFF8;
    #1 check((m_cnt[W-1:0] == '0) ? "R3" : "R2", bus_rdata, m_cnt[W-1:0]);
    bus_addr = 16'hBFFC;
    #1 check("R3", bus_rdata, m_cnt[2*W-1:W]);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    read_chk("R1", 16'h4000, '0);
    read_chk("R1", 16'h4004, '0);
    read_chk("R1", 16'hBFF8, '0);
    read_chk("R1", 16'hBFFC, '0);
    check("R1", W'(timer_irq), '0);

    // Register access table, counter stopped
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) bus_write(VECS[i].ofs, VECS[i].wd);
      read_chk(VECS[i].we ? "R9" : "R8", VECS[i].ofs, VECS[i].exp);
    end
    read_chk("R2", 16'hBFF8, '0);           // no ticks yet: counter held
    check("R7", W'(timer_irq), '0);

    // R6: zero compare across a low-word wrap
    bus_write(16'h4000, '0);
    bus_write(16'h4004, '0);
    for (int i = 0; i < 300; i++) do_tick();

    // R1: reset mid-run clears everything
    bus_write(16'h4004, 8'h09);
    do_reset();
    read_chk("R1", 16'hBFF8, '0);
    read_chk("R1", 16'hBFFC, '0);
    read_chk("R1", 16'h4004, '0);
    check("R1", W'(timer_irq), '0);

    // R4/R5: compare 0x0105
    bus_write(16'h4000, 8'h05);
    bus_write(16'h4004, 8'h01);
    while (m_cnt != 16'h0105) do_tick();
    check("R5", W'(timer_irq), 8'h01);

    // R7: compare moved between ticks; request holds until next tick
    bus_write(16'h4000, 8'h07);
    repeat (3) @(negedge clk);
    check("R7", W'(timer_irq), 8'h01);
    do_tick();                               // 0x0106: high equal, low differs
    check("R5", W'(timer_irq), 8'h00);
    do_tick();                               // 0x0107: exact match
    check("R5", W'(timer_irq), 8'h01);
    do_tick();                               // 0x0108: high equal, low past
    check("R5", W'(timer_irq), 8'h00);
    while (m_cnt != 16'h0200) do_tick();
    check("R4", W'(timer_irq), 8'h01);
    repeat (20) do_tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule